// File: doc/BRIEF.md
# Resistive Crossbar Access Controller

This block sequences single-cell operations on a two-row resistive crossbar with a parameterised number of columns. A host presents a read or write command together with a row and a column address. The controller then holds the array in a read, set or reset condition. It does not produce analog voltages itself. For every bit line, source line and word line it emits a 2-bit drive-select code, and an external analog driver turns each code into a voltage.

A read holds the addressed cell under read bias until the host raises stop. A write with data 1 programs the cell toward low resistance (set), using a compliance-limited word-line level. A write with data 0 programs it back (reset). Each programming pulse lasts a number of clock cycles taken from an input at the moment the write starts. When any operation ends, the controller drops busy and raises done for one cycle.

Top module: `xbar_access_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the controller is idle: every code is 00, and busy and done are 0.
- R2: In idle, an asserted read command starts a read at the next clock edge. This holds even when a write command is asserted in the same cycle.
- R3: In idle, a write command with stop low and no read starts a set when write data is 1 and a reset when it is 0. A write command with stop high is ignored.
- R4: During a read, the addressed column's bit line is 01, the addressed row's source line is 01, the addressed row's word line is 11, and all other lines are 00.
- R5: During a set, every bit line is 00, the addressed row's source line is 10, the addressed row's word line is 11 (compliance level), and all other lines are 00.
- R6: During a reset, the addressed column's bit line is 10, every source line is 00, the addressed row's word line is 11, and all other lines are 00.
- R7: A read stays active for as long as stop is low. The first clock edge with stop high returns the controller to idle.
- R8: A set or reset lasts exactly max(P,1) cycles, where P is the pulse-length input sampled when the write starts. Stop and new commands have no effect during this time.
- R9: Busy is 1 exactly while an operation is active. Done is 1 only for the single cycle after an operation ends.
- R10: Row and column addresses are captured when an operation starts. Address changes during the operation do not move the driven lines.
- R11: In idle, all bit, source and word line codes are 00. A new command is accepted in the same cycle that done is high.
- Code encoding: bit line c uses bits [2c+1:2c] of the bit-line bus, and row r uses bits [2r+1:2r] of the source-line and word-line buses. The codes are 00 = ground, 01 = read/reference level, 10 = program level, 11 = supply/compliance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_cmd | input | 1 | Read command |
| wr_cmd | input | 1 | Write command |
| stop | input | 1 | Ends a read; blocks a write start |
| wr_data | input | 1 | 1 = set, 0 = reset |
| row_addr | input | 1 | Row to access |
| col_addr | input | CW | Column to access |
| pulse_len | input | PW_W | Programming pulse length in cycles |
| bl_code | output | 2*N_COLS | Bit-line drive codes |
| sl_code | output | 4 | Source-line drive codes |
| wl_code | output | 4 | Word-line drive codes |
| busy | output | 1 | Operation active |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
Two functions can fall in the same cycle in two ways:
- A read command and a write command can be presented together in idle.
- The done pulse of one operation can coincide with the start command of the next.

Directed steps raise both commands at once and check that only the read bias pattern appears. Other directed steps issue a new command on the exact cycle done is high and check that the new operation's line codes appear on the following cycle. Random traffic adds stop pulses, address changes and zero pulse lengths during programming. A cycle-level bench model compares every line code, busy and done against these cases.

// File: rtl/xbar_access_ctrl.sv
module xbar_access_ctrl #(
  parameter int N_COLS = 8,
  parameter int PW_W   = 8,
  localparam int CW    = (N_COLS > 1) ? $clog2(N_COLS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_cmd,
  input  logic                  wr_cmd,
  input  logic                  stop,
  input  logic                  wr_data,
  input  logic                  row_addr,
  input  logic [CW-1:0]         col_addr,
  input  logic [PW_W-1:0]       pulse_len,
  output logic [2*N_COLS-1:0]   bl_code,
  output logic [3:0]            sl_code,
  output logic [3:0]            wl_code,
  output logic                  busy,
  output logic                  done
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_SET, S_RST} st_t;

  st_t             st;
  logic            row_q;
  logic [CW-1:0]   col_q;
  logic [PW_W-1:0] cnt;
  logic [1:0]      bl_lvl, sl_lvl, wl_lvl;
  logic [1:0]      wl_on;

  wire start_wr = wr_cmd && !stop && !rd_cmd;
  wire [PW_W-1:0] pl_eff = (pulse_len == '0) ? PW_W'(1) : pulse_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      row_q <= 1'b0;
      col_q <= '0;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (rd_cmd || start_wr) begin
            row_q <= row_addr;
            col_q <= col_addr;
            cnt   <= pl_eff;
          end
          if (rd_cmd)        st <= S_READ;
          else if (start_wr) st <= wr_data ? S_SET : S_RST;
        end
        S_READ: begin
          if (stop) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        default: begin
          if (cnt == PW_W'(1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            cnt <= cnt - PW_W'(1);
          end
        end
      endcase
    end
  end

  assign busy   = (st != S_IDLE);
  assign bl_lvl = (st == S_READ) ? 2'b01 : (st == S_RST) ? 2'b10 : 2'b00;
  assign sl_lvl = (st == S_READ) ? 2'b01 : (st == S_SET) ? 2'b10 : 2'b00;
  assign wl_lvl = busy ? 2'b11 : 2'b00;

  for (genvar c = 0; c < N_COLS; c++) begin : g_bl
    assign bl_code[2*c +: 2] = (col_q == CW'(c)) ? bl_lvl : 2'b00;
  end

  for (genvar r = 0; r < 2; r++) begin : g_row
    assign sl_code[2*r +: 2] = (row_q == 1'(r)) ? sl_lvl : 2'b00;
    assign wl_code[2*r +: 2] = (row_q == 1'(r)) ? wl_lvl : 2'b00;
    assign wl_on[r]          = (wl_code[2*r +: 2] != 2'b00);
  end

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_one_row_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wl_on));
  assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ && !stop) |=> (st == S_READ));
  assert_prog_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_SET || st == S_RST) && cnt != PW_W'(1)) |=> $stable(st) && $stable(row_q) && $stable(col_q));
  assert_set_bl_ground_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SET) |-> (bl_code == '0));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (wl_code == 4'b0 && sl_code == 4'b0));

endmodule

// File: tb/xbar_access_ctrl_bench.sv
module xbar_access_ctrl_bench;
  localparam int N  = 8;
  localparam int PW = 8;
  localparam int CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_cmd = 0, wr_cmd = 0, stop = 0, wr_data = 0, row_addr = 0;
  logic [CW-1:0] col_addr = '0;
  logic [PW-1:0] pulse_len = '0;
  logic [2*N-1:0] bl_code;
  logic [3:0] sl_code, wl_code;
  logic busy, done;

  int checks = 0, errors = 0;
  bit finished = 0;
  string tag = "";

  int m_st = 0; // 0 idle 1 read 2 set 3 reset
  int m_cnt = 0, m_col = 0;
  bit m_row = 0, m_done = 0;

  always #10 clk = ~clk;

  xbar_access_ctrl #(.N_COLS(N), .PW_W(PW)) u_xbar_access_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .stop(stop),
    .wr_data(wr_data), .row_addr(row_addr), .col_addr(col_addr),
    .pulse_len(pulse_len), .bl_code(bl_code), .sl_code(sl_code),
    .wl_code(wl_code), .busy(busy), .done(done));

  function automatic logic [2*N-1:0] exp_bl();
    logic [2*N-1:0] v = '0;
    if (m_st == 1) v[2*m_col +: 2] = 2'b01;
    if (m_st == 3) v[2*m_col +: 2] = 2'b10;
    return v;
  endfunction

  function automatic logic [3:0] exp_sl();
    logic [3:0] v = '0;
    if (m_st == 1) v[2*m_row +: 2] = 2'b01;
    if (m_st == 2) v[2*m_row +: 2] = 2'b10;
    return v;
  endfunction

  function automatic logic [3:0] exp_wl();
    logic [3:0] v = '0;
    if (m_st != 0) v[2*m_row +: 2] = 2'b11;
    return v;
  endfunction

  task automatic chk(string t, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic check_all();
    string st_tag;
    case (m_st)
      0: st_tag = "R11"; 1: st_tag = "R4"; 2: st_tag = "R5"; default: st_tag = "R6";
    endcase
    if (tag != "") st_tag = tag;
    chk({st_tag, " bl"}, 64'(bl_code), 64'(exp_bl()));
    chk({st_tag, " sl"}, 64'(sl_code), 64'(exp_sl()));
    chk({st_tag, " wl"}, 64'(wl_code), 64'(exp_wl()));
    chk("R9 busy", 64'(busy), 64'(m_st != 0));
    chk("R9 done", 64'(done), 64'(m_done));
  endtask

  task automatic step(bit rd, bit wr, bit sp, bit wd, bit row, int col, int pl);
    @(negedge clk);
    check_all();
    rd_cmd = rd; wr_cmd = wr; stop = sp; wr_data = wd;
    row_addr = row; col_addr = CW'(col); pulse_len = PW'(pl);
    m_done = 0;
    case (m_st)
      0: if (rd) begin
           m_st = 1; m_row = row; m_col = col;
         end else if (wr && !sp) begin
           m_st = wd ? 2 : 3; m_row = row; m_col = col;
           m_cnt = (pl == 0) ? 1 : pl;
         end
      1: if (sp) begin m_st = 0; m_done = 1; end
      default: if (m_cnt == 1) begin m_st = 0; m_done = 1; end
               else m_cnt--;
    endcase
  endtask

  task automatic idle_n(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1 bl in reset", 64'(bl_code), 64'(0));
    chk("R1 wl in reset", 64'(wl_code), 64'(0));
    chk("R1 busy in reset", 64'(busy), 64'(0));
    chk("R1 done in reset", 64'(done), 64'(0));
    rst_n = 1'b1;
    tag = "R1"; idle_n(2);

    tag = "R2"; step(1, 1, 0, 1, 1, 5, 3); step(0, 0, 0, 0, 0, 0, 0);
    tag = "R7"; idle_n(3); step(0, 0, 1, 0, 0, 0, 0);
    tag = "R11"; step(0, 1, 0, 0, 0, 2, 4);
    tag = "R10"; step(0, 0, 1, 1, 1, 7, 9); step(1, 1, 0, 0, 1, 6, 0); idle_n(3);
    tag = "R3"; step(0, 1, 1, 1, 0, 1, 2); idle_n(2);
    step(0, 1, 0, 1, 0, 3, 0); step(0, 0, 0, 0, 0, 0, 0);
    tag = "R8"; step(0, 1, 0, 0, 1, 4, 1); step(0, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 1, 0, N - 1, 5); step(0, 0, 1, 0, 0, 0, 0); idle_n(6);
    tag = "R11"; step(1, 0, 0, 0, 0, 0, 0); step(0, 0, 1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 1, 0, 2); idle_n(4);
    tag = "";

    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      step(r < 15, (r >= 10) && (r < 45), $urandom_range(0, 4) == 0,
           1'($urandom), 1'($urandom), $urandom_range(0, N - 1),
           $urandom_range(0, 6));
    end
    idle_n(2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule